// File: doc/BRIEF.md
# Banked Data Pointer Register File

This block keeps eight independent 16-bit data pointers for an 8051-compatible core. Software sees only the active one. It appears through two byte-wide special-function registers, one for the low byte and one for the high byte. A small select register chooses which pointer is active. Software can therefore keep a source pointer and a destination pointer live at the same time, and switch between them with one register write instead of saving and restoring bytes.

The instruction decoder drives two strobes: one loads a 16-bit immediate into the active pointer, and one increments it. The active pointer is always presented on a 16-bit address output for external data and code fetches. When the select register stays at zero, the block behaves exactly like the single data pointer of a classic 8051.

Top module: `dptr_bank`

## Requirements
- R1: After reset, every pointer and the select register are zero, so the address output and all three register reads return zero.
- R2: A write to the select register (default address 0x92) stores the low 3 bits of the write data and ignores bits 7..3. A read of it returns those 3 bits with bits 7..3 as zero.
- R3: A write to the low-byte register (address 0x82) changes only bits 7..0 of the selected pointer. A write to the high-byte register (address 0x83) changes only bits 15..8 of the selected pointer.
- R4: A read of the low-byte or high-byte register returns that byte of the selected pointer. A read of any other address returns zero.
- R5: An increment strobe adds 1 to the selected pointer with a full 16-bit carry, and wraps 0xFFFF to 0x0000. The other seven pointers do not change.
- R6: A load strobe writes all 16 bits of the selected pointer from the immediate input in one cycle.
- R7: When operations on the selected pointer coincide in one cycle, a load wins over an increment, and an increment wins over a byte write through the register port.
- R8: A new select value takes effect from the next cycle on. Operations in the same cycle as the select write still act on the old pointer, and every pointer that is not selected keeps its value.
- R9: The address output always equals the full 16-bit value of the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | Register port address |
| sfr_wdata_i | input | 8 | Register port write data |
| sfr_we_i | input | 1 | Register port write strobe |
| sfr_rdata_o | output | 8 | Register port read data (combinational) |
| ptr_load_i | input | 1 | Load the immediate into the selected pointer |
| ptr_load_val_i | input | 16 | Immediate value for the load |
| ptr_inc_i | input | 1 | Increment the selected pointer |
| ptr_addr_o | output | 16 | Selected pointer, used as the external address |

## Verification
The bench builds the block with its default parameters: eight pointers, byte-wide halves, and register addresses 0x82, 0x83 and 0x92. With only eight 16-bit pointers, the bench can visit every pointer after each stimulus and sweep all 256 select write values, so every stray write into an unselected pointer shows up. A 300-step increment run crosses both the byte carry and the 0xFFFF wrap. It is driven together with coincident-operation cases that exercise the priority order and the timing of a select change.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam logic [7:0]  ADDR_LO_DEF  = 8'h82;
  localparam logic [7:0]  ADDR_HI_DEF  = 8'h83;
  localparam logic [7:0]  ADDR_SEL_DEF = 8'h92;

  typedef struct packed {
    logic load;
    logic inc;
    logic wr_lo;
    logic wr_hi;
  } ptr_op_t;
endpackage

// File: rtl/dptr_sel_reg.sv
module dptr_sel_reg #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wdata_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= '0;
    else if (wr_i) sel_o <= wdata_i;
  end
endmodule

// File: rtl/dptr_word.sv
module dptr_word
  import dptr_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  ptr_op_t         op_i,
  input  logic [2*BW-1:0] load_val_i,
  input  logic [BW-1:0]   wdata_i,
  output logic [2*BW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (en_i) begin
      // load > inc > byte writes
      if (op_i.load)     q_o <= load_val_i;
      else if (op_i.inc) q_o <= q_o + 1'b1;
      else begin
        if (op_i.wr_lo) q_o[BW-1:0]    <= wdata_i;
        if (op_i.wr_hi) q_o[2*BW-1:BW] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/dptr_rd_mux.sv
module dptr_rd_mux #(
  parameter int unsigned BW       = 8,
  parameter int unsigned SEL_W    = 3,
  parameter logic [7:0]  ADDR_LO  = 8'h82,
  parameter logic [7:0]  ADDR_HI  = 8'h83,
  parameter logic [7:0]  ADDR_SEL = 8'h92
) (
  input  logic [7:0]      addr_i,
  input  logic [2*BW-1:0] cur_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [BW-1:0]   rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_LO)       rdata_o = cur_i[BW-1:0];
    else if (addr_i == ADDR_HI)  rdata_o = cur_i[2*BW-1:BW];
    else if (addr_i == ADDR_SEL) rdata_o = BW'(sel_i);
  end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import dptr_pkg::*;
#(
  parameter int unsigned NUM_PTR  = 8,
  parameter logic [7:0]  ADDR_LO  = ADDR_LO_DEF,
  parameter logic [7:0]  ADDR_HI  = ADDR_HI_DEF,
  parameter logic [7:0]  ADDR_SEL = ADDR_SEL_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    sfr_addr_i,
  input  logic [7:0]    sfr_wdata_i,
  input  logic          sfr_we_i,
  output logic [7:0]    sfr_rdata_o,
  input  logic          ptr_load_i,
  input  logic [15:0]   ptr_load_val_i,
  input  logic          ptr_inc_i,
  output logic [15:0]   ptr_addr_o
);
  localparam int unsigned SEL_W = $clog2(NUM_PTR);
  localparam int unsigned PW    = 2 * BYTE_W;

  logic [SEL_W-1:0] sel;
  logic [PW-1:0]    ptr_q [NUM_PTR];
  ptr_op_t          op;

  always_comb begin
    op.load  = ptr_load_i;
    op.inc   = ptr_inc_i;
    op.wr_lo = sfr_we_i && (sfr_addr_i == ADDR_LO);
    op.wr_hi = sfr_we_i && (sfr_addr_i == ADDR_HI);
  end

  dptr_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sfr_we_i && (sfr_addr_i == ADDR_SEL)),
    .wdata_i (sfr_wdata_i[SEL_W-1:0]),
    .sel_o   (sel)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    dptr_word #(.BW(BYTE_W)) u_word (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (sel == SEL_W'(g)),
      .op_i       (op),
      .load_val_i (ptr_load_val_i),
      .wdata_i    (sfr_wdata_i),
      .q_o        (ptr_q[g])
    );
  end

  assign ptr_addr_o = ptr_q[sel];

  dptr_rd_mux #(
    .BW(BYTE_W), .SEL_W(SEL_W),
    .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .ADDR_SEL(ADDR_SEL)
  ) u_rd (
    .addr_i  (sfr_addr_i),
    .cur_i   (ptr_addr_o),
    .sel_i   (sel),
    .rdata_o (sfr_rdata_o)
  );
endmodule

// File: rtl/dptr_bank_chk.sv
module dptr_bank_chk
  import dptr_pkg::*;
#(
  parameter int unsigned NUM_PTR = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  sfr_addr_i,
  input logic [7:0]  sfr_wdata_i,
  input logic        sfr_we_i,
  input logic [7:0]  sfr_rdata_o,
  input logic        ptr_load_i,
  input logic [15:0] ptr_load_val_i,
  input logic        ptr_inc_i,
  input logic [15:0] ptr_addr_o
);
  localparam int unsigned SEL_W = $clog2(NUM_PTR);
  logic sel_wr;
  assign sel_wr = sfr_we_i && (sfr_addr_i == ADDR_SEL_DEF);

  AST_SEL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == ADDR_SEL_DEF) |-> (sfr_rdata_o[7:SEL_W] == '0)); // R2

  AST_LO_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == ADDR_LO_DEF) |-> (sfr_rdata_o == ptr_addr_o[7:0])); // R4

  AST_HI_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == ADDR_HI_DEF) |-> (sfr_rdata_o == ptr_addr_o[15:8])); // R4

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_inc_i && !ptr_load_i && !sel_wr) |=> (ptr_addr_o == $past(ptr_addr_o) + 16'd1)); // R5

  AST_LOAD_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_load_i && !sel_wr) |=> (ptr_addr_o == $past(ptr_load_val_i))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_load_i && !ptr_inc_i && !sfr_we_i) |=> $stable(ptr_addr_o)); // R8
endmodule

bind dptr_bank dptr_bank_chk #(.NUM_PTR(8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sfr_addr_i(sfr_addr_i), .sfr_wdata_i(sfr_wdata_i),
  .sfr_we_i(sfr_we_i), .sfr_rdata_o(sfr_rdata_o), .ptr_load_i(ptr_load_i),
  .ptr_load_val_i(ptr_load_val_i), .ptr_inc_i(ptr_inc_i), .ptr_addr_o(ptr_addr_o)
);

// File: tb/dptr_bank_test.sv
module dptr_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_LO = 8'h82, A_HI = 8'h83, A_SEL = 8'h92;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sfr_addr_i = 8'h00;
  logic [7:0]  sfr_wdata_i = 8'h00;
  logic        sfr_we_i = 1'b0;
  logic [7:0]  sfr_rdata_o;
  logic        ptr_load_i = 1'b0;
  logic [15:0] ptr_load_val_i = 16'h0000;
  logic        ptr_inc_i = 1'b0;
  logic [15:0] ptr_addr_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_p [8];
  logic [2:0]  exp_sel;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dptr_bank uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr_i = a; sfr_wdata_i = d; sfr_we_i = 1'b1;
    tick();
    sfr_we_i = 1'b0;
    if (a == A_LO) exp_p[exp_sel][7:0] = d;
    if (a == A_HI) exp_p[exp_sel][15:8] = d;
    if (a == A_SEL) exp_sel = d[2:0];
  endtask

  task automatic op_load(input logic [15:0] v);
    ptr_load_i = 1'b1; ptr_load_val_i = v;
    tick();
    ptr_load_i = 1'b0;
    exp_p[exp_sel] = v;
  endtask

  task automatic op_inc();
    ptr_inc_i = 1'b1;
    tick();
    ptr_inc_i = 1'b0;
    exp_p[exp_sel] = exp_p[exp_sel] + 16'd1;
  endtask

  // visit every pointer through the normal interface, then restore select
  task automatic check_all(input string req);
    logic [2:0] keep;
    keep = exp_sel;
    for (int i = 0; i < 8; i++) begin
      sfr_wr(A_SEL, 8'(i));
      chk(ptr_addr_o == exp_p[i], req, ptr_addr_o, exp_p[i]);
      sfr_addr_i = A_LO; #1;
      chk(sfr_rdata_o == exp_p[i][7:0], "R4 lo", sfr_rdata_o, exp_p[i][7:0]);
      sfr_addr_i = A_HI; #1;
      chk(sfr_rdata_o == exp_p[i][15:8], "R4 hi", sfr_rdata_o, exp_p[i][15:8]);
    end
    sfr_wr(A_SEL, 8'(keep));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_p[i] = 16'h0;
    exp_sel = 3'd0;
    #(CLK_PERIOD * 3 + 1);
    rst_ni = 1'b1;
    tick();

    // R1: reset state
    chk(ptr_addr_o == 16'h0, "R1 addr", ptr_addr_o, 0);
    sfr_addr_i = A_SEL; #1;
    chk(sfr_rdata_o == 8'h0, "R1 sel", sfr_rdata_o, 0);
    check_all("R1 ptr");

    // R2: sweep all select write values
    for (int v = 0; v < 256; v++) begin
      sfr_wr(A_SEL, 8'(v));
      sfr_addr_i = A_SEL; #1;
      chk(sfr_rdata_o == 8'(v & 7), "R2 sel readback", sfr_rdata_o, v & 7);
    end
    sfr_wr(A_SEL, 8'h00);

    // R4: unmapped addresses read zero
    sfr_addr_i = 8'h81; #1;
    chk(sfr_rdata_o == 8'h0, "R4 unmapped", sfr_rdata_o, 0);
    sfr_addr_i = 8'h84; #1;
    chk(sfr_rdata_o == 8'h0, "R4 unmapped", sfr_rdata_o, 0);

    // R6: distinct load per pointer, R8 retention across switching
    for (int i = 0; i < 8; i++) begin
      sfr_wr(A_SEL, 8'(i));
      op_load(16'h1111 * 16'(i) + 16'h0A05);
      chk(ptr_addr_o == exp_p[i], "R6 load", ptr_addr_o, exp_p[i]);
    end
    check_all("R8 retain");

    // R3: byte writes on several pointers
    sfr_wr(A_SEL, 8'd3); sfr_wr(A_LO, 8'hC7);
    check_all("R3 lo write");
    sfr_wr(A_SEL, 8'd6); sfr_wr(A_HI, 8'h5E);
    check_all("R3 hi write");

    // R5: wrap on every pointer, others untouched
    for (int i = 0; i < 8; i++) begin
      sfr_wr(A_SEL, 8'(i));
      op_load(16'hFFFE);
      op_inc();
      chk(ptr_addr_o == 16'hFFFF, "R5 inc", ptr_addr_o, 16'hFFFF);
      op_inc();
      chk(ptr_addr_o == 16'h0000, "R5 wrap", ptr_addr_o, 0);
      check_all("R5 others");
      op_load(16'h0300 + 16'(i));
    end

    // R5/R9: long run through byte carry and wrap
    sfr_wr(A_SEL, 8'd5);
    op_load(16'hFF00);
    for (int k = 1; k <= 300; k++) begin
      op_inc();
      chk(ptr_addr_o == 16'((32'hFF00 + k) & 32'hFFFF), "R9 inc run", ptr_addr_o,
          (32'hFF00 + k) & 32'hFFFF);
    end
    check_all("R5 run others");

    // R7: load beats inc and byte write
    sfr_wr(A_SEL, 8'd2);
    ptr_load_i = 1'b1; ptr_load_val_i = 16'hBEEF; ptr_inc_i = 1'b1;
    sfr_addr_i = A_LO; sfr_wdata_i = 8'h11; sfr_we_i = 1'b1;
    tick();
    ptr_load_i = 1'b0; ptr_inc_i = 1'b0; sfr_we_i = 1'b0;
    exp_p[2] = 16'hBEEF;
    chk(ptr_addr_o == 16'hBEEF, "R7 load wins", ptr_addr_o, 16'hBEEF);
    // R7: inc beats byte write
    ptr_inc_i = 1'b1; sfr_addr_i = A_HI; sfr_wdata_i = 8'h22; sfr_we_i = 1'b1;
    tick();
    ptr_inc_i = 1'b0; sfr_we_i = 1'b0;
    exp_p[2] = 16'hBEF0;
    chk(ptr_addr_o == 16'hBEF0, "R7 inc wins", ptr_addr_o, 16'hBEF0);
    check_all("R7 others");

    // R8: op in same cycle as select write hits old pointer
    sfr_wr(A_SEL, 8'd1);
    ptr_load_i = 1'b1; ptr_load_val_i = 16'h4242;
    sfr_addr_i = A_SEL; sfr_wdata_i = 8'd7; sfr_we_i = 1'b1;
    tick();
    ptr_load_i = 1'b0; sfr_we_i = 1'b0;
    exp_p[1] = 16'h4242; exp_sel = 3'd7;
    chk(ptr_addr_o == exp_p[7], "R8 new select", ptr_addr_o, exp_p[7]);
    check_all("R8 old pointer");

    // R9: select zero acts as a single pointer
    sfr_wr(A_SEL, 8'd0);
    op_load(16'h1234); op_inc();
    sfr_wr(A_LO, 8'hAA);
    chk(ptr_addr_o == 16'h12AA, "R9 sel0", ptr_addr_o, 16'h12AA);
    check_all("R9 sel0 others");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule